// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller with Row Refresh

This block is a clocked controller that connects a simple host request port to an asynchronous 64K x 1 dynamic RAM. The DRAM's address pins carry both halves of the address. The host presents a 16-bit address, a read/write flag and one write bit. It holds the request until the controller accepts it. The controller puts the upper address half on the shared pins and pulls the row strobe low. It then switches the pins to the lower half and pulls the column strobe low. Read data is captured while the column strobe is still low and is handed back with a one-cycle valid pulse.

A free-running interval timer raises a refresh request at a fixed cycle period. The default period is 3906 cycles, which is about 15.6 us at 250 MHz. Each refresh is a row-strobe-only cycle: the next row from an internal counter goes onto the pins, the column and write strobes stay high, and no data moves. The counter visits all 256 rows in turn, so the whole array is refreshed every 256 intervals.

Refresh takes priority over host traffic. A host request that is waiting is only accepted once the refresh has finished. Every phase of a cycle lasts a parameterized number of clock cycles: address setup, row-to-column delay, column strobe width and precharge.

Top module: `dramMuxCtrl`

## Requirements
- R1: After reset the row, column and write strobes are high (inactive), the address pins are zero, rdValid is low and reqReady is high.
- R2: An accepted host request first drives the row (reqAddr[15:8]) on the address pins for SETUP_CYC cycles with all strobes high. The row strobe then goes low for RCD_CYC cycles with the row still on the pins.
- R3: After the row phase, the column (reqAddr[7:0]) is on the pins for SETUP_CYC cycles with the row strobe low and the column strobe high. The column strobe is then low for CAS_CYC cycles. Finally every strobe is high and the pins are zero for PRE_CYC precharge cycles before the controller is idle again.
- R4: In a write, the write strobe is low from the first column-setup cycle through the last column-strobe cycle, so it falls before the column strobe does. The DRAM data input carries the host's write bit. In a read, the write strobe stays high.
- R5: In a read, the DRAM data output is sampled in the last cycle the column strobe is low. rdValid pulses high for exactly the first precharge cycle, and rdData holds the sampled bit.
- R6: A refresh becomes pending every REF_INT_CYC clock cycles, counted from reset. The refresh starts on the first idle cycle edge after it becomes pending.
- R7: A refresh drives the row for SETUP_CYC cycles with all strobes high. The row strobe is then low for RCD_CYC+CAS_CYC cycles, followed by PRE_CYC precharge cycles. The column and write strobes stay high for the whole refresh.
- R8: The refresh row starts at 0 after reset, advances by one per refresh, and wraps from 255 to 0.
- R9: reqReady is high only when the controller is idle and no refresh is pending. A request is taken on a clock edge where reqValid and reqReady are both high. A request held during a refresh is taken at the first idle cycle after that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present; held until accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Full address; upper half is the row, lower half the column |
| reqWdata | input | 1 | Bit to write |
| reqReady | output | 1 | Controller can take a request this cycle |
| rdValid | output | 1 | One-cycle pulse marking valid rdData |
| rdData | output | 1 | Last bit read |
| memAddr | output | 8 | Shared row/column address pins |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memWdata | output | 1 | Data into the DRAM |
| memRdata | input | 1 | Data out of the DRAM, valid only while the column strobe is low |

## Verification
The bench builds the controller with SETUP_CYC=2, RCD_CYC=2, CAS_CYC=2, PRE_CYC=1 and REF_INT_CYC=48. Multi-cycle setup and strobe phases expose off-by-one errors in the phase counts. The short refresh interval means that host traffic collides with refresh many times, and the refresh row counter wraps from 255 to 0 within about 12,300 cycles. The bench's DRAM model drives the inverse of the stored bit whenever the column strobe is high, so a read sampled after the strobe is released returns the wrong value.

// File: rtl/dramCtrlPkg.sv
package dramCtrlPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW_SU,
    PH_RAS,
    PH_COL_SU,
    PH_CAS,
    PH_PRE
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeHost;     // latch host address and write bit
    logic takeRefresh;  // latch refresh row, advance row counter, clear pending
    logic driveAddr;    // address pins carry row or column
    logic selCol;       // 1 = column half, 0 = row half
    logic rasOn;
    logic casOn;
    logic weOn;
    logic capture;      // sample DRAM data output this cycle
  } strobe_t;

endpackage

// File: rtl/dramCtrlSeq.sv
module dramCtrlSeq #(
  parameter int SETUP_CYC = 1,
  parameter int RCD_CYC   = 3,
  parameter int CAS_CYC   = 3,
  parameter int PRE_CYC   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 refPending,
  output logic                 reqReady,
  output dramCtrlPkg::strobe_t st
);
  import dramCtrlPkg::*;

  localparam int REF_RAS = RCD_CYC + CAS_CYC;
  localparam int MAX_A   = (SETUP_CYC > REF_RAS) ? SETUP_CYC : REF_RAS;
  localparam int MAX_B   = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REF   = CNT_W'(REF_RAS - 1);
  localparam logic [CNT_W-1:0] LD_CAS   = CNT_W'(CAS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(PRE_CYC - 1);

  phase_e          phase, phaseNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic            isRef, isRefNxt;
  logic            isWr, isWrNxt;
  logic            last;

  assign last = (cnt == '0);

  always_comb begin
    phaseNxt = phase;
    cntNxt   = last ? cnt : cnt - 1'b1;
    isRefNxt = isRef;
    isWrNxt  = isWr;
    st       = '0;
    reqReady = (phase == PH_IDLE) && !refPending;
    unique case (phase)
      PH_IDLE: begin
        if (refPending) begin
          st.takeRefresh = 1'b1;
          phaseNxt       = PH_ROW_SU;
          cntNxt         = LD_SETUP;
          isRefNxt       = 1'b1;
          isWrNxt        = 1'b0;
        end else if (reqValid) begin
          st.takeHost = 1'b1;
          phaseNxt    = PH_ROW_SU;
          cntNxt      = LD_SETUP;
          isRefNxt    = 1'b0;
          isWrNxt     = reqWrite;
        end
      end
      PH_ROW_SU: begin
        st.driveAddr = 1'b1;
        if (last) begin
          phaseNxt = PH_RAS;
          cntNxt   = isRef ? LD_REF : LD_RCD;
        end
      end
      PH_RAS: begin
        st.driveAddr = 1'b1;
        st.rasOn     = 1'b1;
        if (last) begin
          phaseNxt = isRef ? PH_PRE : PH_COL_SU;
          cntNxt   = isRef ? LD_PRE : LD_SETUP;
        end
      end
      PH_COL_SU: begin
        st.driveAddr = 1'b1;
        st.selCol    = 1'b1;
        st.rasOn     = 1'b1;
        st.weOn      = isWr;
        if (last) begin
          phaseNxt = PH_CAS;
          cntNxt   = LD_CAS;
        end
      end
      PH_CAS: begin
        st.driveAddr = 1'b1;
        st.selCol    = 1'b1;
        st.rasOn     = 1'b1;
        st.casOn     = 1'b1;
        st.weOn      = isWr;
        if (last) begin
          st.capture = !isWr;
          phaseNxt   = PH_PRE;
          cntNxt     = LD_PRE;
        end
      end
      PH_PRE: begin
        if (last) phaseNxt = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      isRef <= 1'b0;
      isWr  <= 1'b0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
      isRef <= isRefNxt;
      isWr  <= isWrNxt;
    end
  end

endmodule

// File: rtl/dramCtrlPath.sv
module dramCtrlPath #(
  parameter int HALF_W      = 8,
  parameter int REF_INT_CYC = 3906
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dramCtrlPkg::strobe_t st,
  input  logic [2*HALF_W-1:0]  reqAddr,
  input  logic                 reqWdata,
  output logic                 refPending,
  output logic                 rdValid,
  output logic                 rdData,
  output logic [HALF_W-1:0]    memAddr,
  output logic                 memRasN,
  output logic                 memCasN,
  output logic                 memWeN,
  output logic                 memWdata,
  input  logic                 memRdata
);
  localparam int TMR_W = $clog2(REF_INT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LD = TMR_W'(REF_INT_CYC - 1);

  logic [HALF_W-1:0] rowQ, colQ, refRow;
  logic              wdataQ;
  logic [TMR_W-1:0]  tmr;
  logic              fire;

  assign fire = (tmr == '0);

  // Address and data latches, refresh row counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      wdataQ <= 1'b0;
      refRow <= '0;
    end else if (st.takeHost) begin
      rowQ   <= reqAddr[2*HALF_W-1:HALF_W];
      colQ   <= reqAddr[HALF_W-1:0];
      wdataQ <= reqWdata;
    end else if (st.takeRefresh) begin
      rowQ   <= refRow;
      colQ   <= '0;
      refRow <= refRow + 1'b1;
    end
  end

  // Refresh interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr        <= TMR_LD;
      refPending <= 1'b0;
    end else begin
      tmr <= fire ? TMR_LD : tmr - 1'b1;
      if (fire)                refPending <= 1'b1;
      else if (st.takeRefresh) refPending <= 1'b0;
    end
  end

  // Read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 1'b0;
    end else begin
      rdValid <= st.capture;
      if (st.capture) rdData <= memRdata;
    end
  end

  assign memAddr  = !st.driveAddr ? '0 : (st.selCol ? colQ : rowQ);
  assign memRasN  = !st.rasOn;
  assign memCasN  = !st.casOn;
  assign memWeN   = !st.weOn;
  assign memWdata = wdataQ;

endmodule

// File: rtl/dramMuxCtrl.sv
module dramMuxCtrl #(
  parameter int HALF_W      = 8,
  parameter int SETUP_CYC   = 1,
  parameter int RCD_CYC     = 3,
  parameter int CAS_CYC     = 3,
  parameter int PRE_CYC     = 3,
  parameter int REF_INT_CYC = 3906
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [2*HALF_W-1:0] reqAddr,
  input  logic                reqWdata,
  output logic                reqReady,
  output logic                rdValid,
  output logic                rdData,
  output logic [HALF_W-1:0]   memAddr,
  output logic                memRasN,
  output logic                memCasN,
  output logic                memWeN,
  output logic                memWdata,
  input  logic                memRdata
);
  dramCtrlPkg::strobe_t st;
  logic refPending;

  dramCtrlSeq #(
    .SETUP_CYC(SETUP_CYC), .RCD_CYC(RCD_CYC),
    .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)
  ) uSeq (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .refPending(refPending),
    .reqReady(reqReady), .st(st)
  );

  dramCtrlPath #(
    .HALF_W(HALF_W), .REF_INT_CYC(REF_INT_CYC)
  ) uPath (
    .clk(clk), .rstN(rstN), .st(st),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .refPending(refPending),
    .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: rtl/dramMuxCtrlChecker.sv
module dramMuxCtrlChecker #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [HALF_W-1:0] memAddr,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memWeN
);
  // R3: column strobe only inside an open row
  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    !memCasN |-> !memRasN);

  // R2: row address steady across the row strobe falling edge
  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> $stable(memAddr));

  // R3: column address steady across the column strobe falling edge
  a_r3_col_stable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCasN) |-> $stable(memAddr));

  // R4: write strobe already low a cycle before the column strobe falls
  a_r4_we_leads_cas: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCasN) && !memWeN) |-> !$past(memWeN));

  // R4: write strobe only inside an open row
  a_r4_we_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memRasN);

  // R5: read valid follows release of the column strobe of a read
  a_r5_rdvalid_after_cas: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($rose(memCasN) && $past(memWeN)));

  // R5: single-cycle pulse
  a_r5_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R9: ready only with the DRAM idle
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memRasN && memCasN && memWeN));

endmodule

bind dramMuxCtrl dramMuxCtrlChecker #(.HALF_W(HALF_W)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN)
);

// File: tb/dramMuxCtrl_test.sv
`timescale 1ns/1ps
module dramMuxCtrl_test;
  localparam int S   = 2;
  localparam int D   = 2;
  localparam int C   = 2;
  localparam int P   = 1;
  localparam int INT = 48;
  localparam int RUN = 14000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqWdata = 1'b0;
  logic        reqReady, rdValid, rdData;
  logic [7:0]  memAddr;
  logic        memRasN, memCasN, memWeN, memWdata, memRdata;

  always #2 clk = ~clk;

  dramMuxCtrl #(
    .HALF_W(8), .SETUP_CYC(S), .RCD_CYC(D), .CAS_CYC(C),
    .PRE_CYC(P), .REF_INT_CYC(INT)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Behavioural DRAM: output valid only while the column strobe is low
  bit       dmem [0:65535];
  bit [7:0] rowL, colL;
  always @(negedge memRasN) rowL = memAddr;
  always @(negedge memCasN) begin
    colL = memAddr;
    if (!memWeN) dmem[{rowL, colL}] = memWdata;
  end
  assign memRdata = memCasN ? ~dmem[{rowL, colL}] : dmem[{rowL, colL}];

  // Reference model: queue of expected pin cycles
  typedef struct {
    logic [7:0] a;
    bit ras, cas, we, rdv, rdb;
    string aTag, sTag, wTag;
  } exp_t;
  exp_t q[$];
  bit   shadow [0:65535];
  bit   pend = 0;
  int   cyc = 0;
  bit [7:0] refRowM = 0;
  bit   wasIdle;
  int   vectors = 0, errors = 0;
  int   refreshes = 0, wraps = 0;

  function automatic exp_t mk(logic [7:0] a, bit ras, bit cas, bit we, bit rdv, bit rdb,
                              string aT, string sT, string wT);
    exp_t e;
    e.a = a; e.ras = ras; e.cas = cas; e.we = we; e.rdv = rdv; e.rdb = rdb;
    e.aTag = aT; e.sTag = sT; e.wTag = wT;
    return e;
  endfunction

  task automatic pushRefresh(bit [7:0] r);
    for (int i = 0; i < S; i++)     q.push_back(mk(r, 1, 1, 1, 0, 0, "R6", "R7", "R7"));
    for (int i = 0; i < D + C; i++) q.push_back(mk(r, 0, 1, 1, 0, 0, "R8", "R7", "R7"));
    for (int i = 0; i < P; i++)     q.push_back(mk(8'h00, 1, 1, 1, 0, 0, "R7", "R7", "R7"));
  endtask

  task automatic pushAccess(logic [15:0] ad, bit wr, bit rb);
    bit weX = !wr;
    for (int i = 0; i < S; i++) q.push_back(mk(ad[15:8], 1, 1, 1, 0, 0, "R2", "R2", "R4"));
    for (int i = 0; i < D; i++) q.push_back(mk(ad[15:8], 0, 1, 1, 0, 0, "R2", "R2", "R4"));
    for (int i = 0; i < S; i++) q.push_back(mk(ad[7:0], 0, 1, weX, 0, 0, "R3", "R3", "R4"));
    for (int i = 0; i < C; i++) q.push_back(mk(ad[7:0], 0, 0, weX, 0, 0, "R3", "R3", "R4"));
    for (int i = 0; i < P; i++)
      q.push_back(mk(8'h00, 1, 1, 1, (i == 0) && !wr, rb, "R3", "R3", "R4"));
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      wasIdle = (q.size() == 0);
      if (!wasIdle) void'(q.pop_front());
      else if (pend) begin
        pend = 0;
        pushRefresh(refRowM);
        if (refRowM == 8'hFF) wraps++;
        refRowM++;
        refreshes++;
      end else if (reqValid) begin
        if (reqWrite) shadow[reqAddr] = reqWdata;
        pushAccess(reqAddr, reqWrite, shadow[reqAddr]);
      end
      cyc++;
      if (cyc % INT == 0) pend = 1;
    end
  end

  task automatic chk(string tag, string what, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, expv, cyc);
    end
  endtask

  task automatic compareNow();
    exp_t e;
    if (q.size() != 0) e = q[0];
    else e = mk(8'h00, 1, 1, 1, 0, 0, "R1", "R1", "R1");
    chk(e.aTag, "memAddr", memAddr, e.a);
    chk(e.sTag, "memRasN", memRasN, e.ras);
    chk(e.sTag, "memCasN", memCasN, e.cas);
    chk(e.wTag, "memWeN", memWeN, e.we);
    chk("R9", "reqReady", reqReady, (q.size() == 0) && !pend);
    chk("R5", "rdValid", rdValid, e.rdv);
    if (e.rdv) chk("R5", "rdData", rdData, e.rdb);
    if (!memWeN) chk("R4", "memWdata", memWdata, reqWdataHeld);
  endtask

  bit   reqWdataHeld;
  bit   lastReady = 0;
  bit   done = 0;
  int   wd = 0;

  task automatic newRequest();
    reqValid = 1'b1;
    reqWrite = ($urandom % 2) == 0;
    reqAddr  = {8'($urandom_range(0, 3) * 85), 8'($urandom_range(0, 3) * 60 + 1)};
    reqWdata = $urandom % 2;
  endtask

  always @(posedge clk) if (reqValid && reqReady) reqWdataHeld <= reqWdata;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > 30000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 30000", wd);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "memRasN in reset", memRasN, 1);
    chk("R1", "memCasN in reset", memCasN, 1);
    chk("R1", "memWeN in reset", memWeN, 1);
    chk("R1", "memAddr in reset", memAddr, 0);
    chk("R1", "rdValid in reset", rdValid, 0);
    chk("R1", "reqReady in reset", reqReady, 1);
    rstN = 1'b1;
    for (int n = 0; n < RUN; n++) begin
      @(negedge clk);
      compareNow();
      if (reqValid && lastReady) reqValid = 1'b0;
      lastReady = reqReady;
      if (!reqValid && ($urandom % 3) == 0) newRequest();
    end
    // R8: the refresh row counter must have wrapped past 255 during the run
    chk("R8", "row counter wraps seen", (wraps > 0), 1);
    // R6: refresh count matches the interval
    chk("R6", "refresh count", (refreshes >= RUN / INT - 1), 1);
    finishRun();
  end

endmodule